// File: doc/BRIEF.md
# E1 Basic Frame Aligner

This block finds and keeps basic frame alignment on a received 2.048 Mbit/s E1 bit stream. Bits arrive one at a time on a data input qualified by a valid strobe. Each frame is 256 bits long. Timeslot 0 of every other frame carries the 7-bit alignment pattern, and timeslot 0 of the frames in between carries a service word. While out of alignment the block hunts through every bit position for the pattern. It then confirms a candidate over three frames before it declares alignment. Once aligned, it checks the pattern and the service word at the expected position in every frame, and drops alignment when errors persist.

The block drives a loss-of-alignment flag and pulses an interrupt when that flag rises. It marks the start of each frame while aligned. When multiframe operation is enabled, it pulses a multiframe-resync request after alignment is regained, so that a downstream CRC-4 multiframe aligner starts its own search only once basic alignment exists. Recovery after a loss needs no software action. Configuration inputs pick a loss threshold of 3 or 4 consecutive errors, and decide whether service-word errors can cause loss.

Top module: `e1_frame_align`

## Requirements
- R1: After synchronous reset, lfa_o is 1, and lfa_irq_o, frame_start_o and mf_resync_o are 0.
- R2: The alignment pattern is 0011011 in bits 2 to 8 of timeslot 0, with bit 2 received first and bit 8 last. Frames are 256 bits. Frames carrying the pattern alternate with frames carrying the service word. While hunting, every accepted bit position is a candidate. The 7-bit receive history is all zeros after reset.
- R3: From hunting, alignment is regained only through a fixed sequence. The pattern ends at some bit (frame n). Bit 2 of the service word is 1 in frame n+1 at the same position. The pattern appears again in frame n+2. lfa_o goes to 0 in the cycle after bit 8 of that second pattern is accepted.
- R4: If the service-word step or the second-pattern step fails, the block returns to hunting, and the hunt resumes with the next accepted bit. lfa_o stays 1 throughout.
- R5: While aligned, lfa_o rises in the cycle after bit 8 of the Nth consecutive wrong pattern is accepted. N is 4 when cfg_thr4_i is 1 and 3 when it is 0. A correct pattern clears the run.
- R6: While aligned and cfg_sw_loss_i is 1, N consecutive service words with bit 2 equal to 0 raise lfa_o in the same way. When cfg_sw_loss_i is 0, service-word errors have no effect on lfa_o.
- R7: lfa_irq_o is high for exactly one cycle, in the cycle after each rising edge of lfa_o, and at no other time.
- R8: frame_start_o is high for one cycle, in the cycle after bit 1 (the first bit) of a frame is accepted while lfa_o is 0.
- R9: When cfg_mf_en_i is 1, mf_resync_o is high for one cycle, in the cycle after each falling edge of lfa_o. It is never high when cfg_mf_en_i was 0 on the previous cycle.
- R10: In a cycle with bit_vld_i low, bit_i is ignored and the bit position and alignment state do not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_vld_i | input | 1 | Received bit is valid this cycle |
| bit_i | input | 1 | Received serial data bit |
| cfg_thr4_i | input | 1 | 1: loss after 4 errors, 0: after 3 |
| cfg_sw_loss_i | input | 1 | Service-word errors may cause loss |
| cfg_mf_en_i | input | 1 | Multiframe operation enabled |
| lfa_o | output | 1 | Loss of frame alignment |
| lfa_irq_o | output | 1 | One-cycle pulse on rise of lfa_o |
| frame_start_o | output | 1 | One-cycle pulse per aligned frame |
| mf_resync_o | output | 1 | One-cycle multiframe-resync request |

## Verification
The hardest case to reach from the ports is a regain attempt that fails partway. This needs a correct pattern followed by a bad service word. Then the next pattern must be caught two frames later, not lost to a false lock inside random payload. The directed part of the stimulus fills payload and spare service bits with ones, so that no false pattern can appear. This places the failed and the successful attempt at known frames. A random phase with random payload, corruption and strobe gaps is then compared cycle by cycle against a bench model.

// File: rtl/e1fa_pkg.sv
package e1fa_pkg;
  typedef enum logic [1:0] {
    ST_HUNT     = 2'd0,
    ST_WAIT_SW  = 2'd1,
    ST_WAIT_FAS = 2'd2,
    ST_SYNC     = 2'd3
  } fa_state_t;
endpackage

// File: rtl/e1fa_window.sv
module e1fa_window #(
  parameter int               FAS_W   = 7,
  parameter logic [FAS_W-1:0] FAS_PAT = 7'b0011011
) (
  input  logic clk,
  input  logic rst,
  input  logic vld_i,
  input  logic din_i,
  output logic fas_hit_o,
  output logic sw_bit_o
);
  logic [FAS_W-1:0] win_q;
  logic [FAS_W-1:0] win_nxt;

  // history including the bit being accepted now
  assign win_nxt   = {win_q[FAS_W-2:0], din_i};
  assign fas_hit_o = (win_nxt == FAS_PAT);
  assign sw_bit_o  = win_nxt[FAS_W-1];   // oldest of the seven = bit 2

  always_ff @(posedge clk) begin
    if (rst)        win_q <= '0;
    else if (vld_i) win_q <= win_nxt;
  end
endmodule

// File: rtl/e1fa_pos.sv
module e1fa_pos #(
  parameter int FRAME_BITS = 256,
  parameter int POS_W      = 8,
  parameter int LOAD_POS   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld_i,
  input  logic             load_i,
  output logic [POS_W-1:0] pos_o,
  output logic             fas_frame_o
);
  localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_BITS - 1);
  localparam logic [POS_W-1:0] LOADV = POS_W'(LOAD_POS);

  logic [POS_W-1:0] pos_q;
  logic             ff_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
      ff_q  <= 1'b0;
    end else if (vld_i) begin
      if (load_i) begin
        pos_q <= LOADV;
        ff_q  <= 1'b1;
      end else if (pos_q == LAST) begin
        pos_q <= '0;
        ff_q  <= ~ff_q;
      end else begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  assign pos_o       = pos_q;
  assign fas_frame_o = ff_q;

  // R10: no strobe, no movement
  p_pos_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !vld_i |=> $stable(pos_q) && $stable(ff_q));
endmodule

// File: rtl/e1fa_fsm.sv
module e1fa_fsm
  import e1fa_pkg::*;
#(
  parameter int POS_W   = 8,
  parameter int CHK_POS = 7,
  parameter int LOSS_LO = 3,
  parameter int LOSS_HI = 4,
  parameter int CNT_W   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld_i,
  input  logic             fas_hit_i,
  input  logic             sw_bit_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic             fas_frame_i,
  input  logic             cfg_thr4_i,
  input  logic             cfg_sw_loss_i,
  output logic             load_o,
  output logic             lfa_o
);
  fa_state_t        st_q, st_n;
  logic             lfa_q, lfa_n;
  logic [CNT_W-1:0] fc_q, fc_n, sc_q, sc_n;
  logic [CNT_W-1:0] thr;
  logic             chk;

  assign thr = cfg_thr4_i ? CNT_W'(LOSS_HI) : CNT_W'(LOSS_LO);
  assign chk = vld_i && (pos_i == POS_W'(CHK_POS));

  always_comb begin
    st_n   = st_q;
    lfa_n  = lfa_q;
    fc_n   = fc_q;
    sc_n   = sc_q;
    load_o = 1'b0;
    unique case (st_q)
      ST_HUNT: begin
        if (vld_i && fas_hit_i) begin
          load_o = 1'b1;
          st_n   = ST_WAIT_SW;
        end
      end
      ST_WAIT_SW: begin
        if (chk) st_n = (!fas_frame_i && sw_bit_i) ? ST_WAIT_FAS : ST_HUNT;
      end
      ST_WAIT_FAS: begin
        if (chk) begin
          if (fas_hit_i) begin
            st_n  = ST_SYNC;
            lfa_n = 1'b0;
            fc_n  = '0;
            sc_n  = '0;
          end else begin
            st_n = ST_HUNT;
          end
        end
      end
      ST_SYNC: begin
        if (chk) begin
          if (fas_frame_i) begin
            if (fas_hit_i)            fc_n = '0;
            else if (fc_q + 1'b1 >= thr) begin
              st_n  = ST_HUNT;
              lfa_n = 1'b1;
            end else                  fc_n = fc_q + 1'b1;
          end else begin
            if (!cfg_sw_loss_i || sw_bit_i) sc_n = '0;
            else if (sc_q + 1'b1 >= thr) begin
              st_n  = ST_HUNT;
              lfa_n = 1'b1;
            end else                        sc_n = sc_q + 1'b1;
          end
        end
      end
      default: st_n = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_HUNT;
      lfa_q <= 1'b1;
      fc_q  <= '0;
      sc_q  <= '0;
    end else begin
      st_q  <= st_n;
      lfa_q <= lfa_n;
      fc_q  <= fc_n;
      sc_q  <= sc_n;
    end
  end

  assign lfa_o = lfa_q;

  // R3: alignment only ever regained out of the final confirmation step
  p_regain_path_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(lfa_q) |-> $past(st_q) == ST_WAIT_FAS);
  // R4: hunting implies loss is flagged
  p_hunt_flagged_r4: assert property (@(posedge clk) disable iff (rst)
    st_q == ST_HUNT |-> lfa_q);
  // R5: error run never reaches the largest threshold while aligned
  p_run_bound_r5: assert property (@(posedge clk) disable iff (rst)
    st_q == ST_SYNC |-> (fc_q < CNT_W'(LOSS_HI)) && (sc_q < CNT_W'(LOSS_HI)));
endmodule

// File: rtl/e1_frame_align.sv
module e1_frame_align #(
  parameter int               FRAME_BITS = 256,
  parameter int               FAS_W      = 7,
  parameter logic [FAS_W-1:0] FAS_PAT    = 7'b0011011,
  parameter int               LOSS_LO    = 3,
  parameter int               LOSS_HI    = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_vld_i,
  input  logic bit_i,
  input  logic cfg_thr4_i,
  input  logic cfg_sw_loss_i,
  input  logic cfg_mf_en_i,
  output logic lfa_o,
  output logic lfa_irq_o,
  output logic frame_start_o,
  output logic mf_resync_o
);
  localparam int POS_W    = $clog2(FRAME_BITS);
  localparam int CHK_POS  = FAS_W;        // index of bit 8 (0-based)
  localparam int LOAD_POS = FAS_W + 1;    // next index after bit 8
  localparam int CNT_W    = $clog2(LOSS_HI + 1);

  logic             fas_hit, sw_bit, load, fas_frame, lfa;
  logic [POS_W-1:0] pos;
  logic             lfa_d, irq_q, fs_q, mf_q;

  e1fa_window #(.FAS_W(FAS_W), .FAS_PAT(FAS_PAT)) u_win (
    .clk(clk), .rst(rst), .vld_i(bit_vld_i), .din_i(bit_i),
    .fas_hit_o(fas_hit), .sw_bit_o(sw_bit)
  );

  e1fa_pos #(.FRAME_BITS(FRAME_BITS), .POS_W(POS_W), .LOAD_POS(LOAD_POS)) u_pos (
    .clk(clk), .rst(rst), .vld_i(bit_vld_i), .load_i(load),
    .pos_o(pos), .fas_frame_o(fas_frame)
  );

  e1fa_fsm #(.POS_W(POS_W), .CHK_POS(CHK_POS), .LOSS_LO(LOSS_LO),
             .LOSS_HI(LOSS_HI), .CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst(rst), .vld_i(bit_vld_i), .fas_hit_i(fas_hit),
    .sw_bit_i(sw_bit), .pos_i(pos), .fas_frame_i(fas_frame),
    .cfg_thr4_i(cfg_thr4_i), .cfg_sw_loss_i(cfg_sw_loss_i),
    .load_o(load), .lfa_o(lfa)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lfa_d <= 1'b1;
      irq_q <= 1'b0;
      fs_q  <= 1'b0;
      mf_q  <= 1'b0;
    end else begin
      lfa_d <= lfa;
      irq_q <= lfa & ~lfa_d;
      fs_q  <= bit_vld_i && (pos == '0) && !lfa;
      mf_q  <= cfg_mf_en_i & ~lfa & lfa_d;
    end
  end

  assign lfa_o         = lfa;
  assign lfa_irq_o     = irq_q;
  assign frame_start_o = fs_q;
  assign mf_resync_o   = mf_q;

  // R7: every rise of the flag is followed by the interrupt
  p_irq_follows_rise_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(lfa_o) |=> lfa_irq_o);
  // R7: interrupt lasts a single cycle
  p_irq_single_r7: assert property (@(posedge clk) disable iff (rst)
    lfa_irq_o |=> !lfa_irq_o);
  // R8: frame marker only while aligned
  p_fs_aligned_r8: assert property (@(posedge clk) disable iff (rst)
    frame_start_o |-> !lfa_o);
  // R9: resync request only with multiframe operation enabled
  p_mf_enabled_r9: assert property (@(posedge clk) disable iff (rst)
    mf_resync_o |-> $past(cfg_mf_en_i));
endmodule

// File: tb/e1_frame_align_bench.sv
`timescale 1ns/1ps
module e1_frame_align_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_vld_i = 1'b0, bit_i = 1'b0;
  logic cfg_thr4_i = 1'b0, cfg_sw_loss_i = 1'b1, cfg_mf_en_i = 1'b1;
  logic lfa_o, lfa_irq_o, frame_start_o, mf_resync_o;

  always #2.5 clk = ~clk;

  e1_frame_align u_e1_frame_align (
    .clk(clk), .rst(rst), .bit_vld_i(bit_vld_i), .bit_i(bit_i),
    .cfg_thr4_i(cfg_thr4_i), .cfg_sw_loss_i(cfg_sw_loss_i), .cfg_mf_en_i(cfg_mf_en_i),
    .lfa_o(lfa_o), .lfa_irq_o(lfa_irq_o), .frame_start_o(frame_start_o),
    .mf_resync_o(mf_resync_o)
  );

  int n_chk = 0, n_bad = 0;
  string cur_tag = "R2";

  // reference model state
  int mst = 0, mpos = 0, mfc = 0, msc = 0;
  logic [6:0] mwin = '0;
  bit mff = 0, mlfa = 1, mlfa_d = 1;
  bit e_irq = 0, e_fs = 0, e_mf = 0;

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // expected behaviour of one clock edge, from the requirements
  function automatic void model_edge(bit vld, bit b);
    bit [6:0] nw;
    bit hit, sb, ck, ld;
    int thr;
    e_fs  = vld && mpos == 0 && !mlfa;
    e_irq = mlfa && !mlfa_d;
    e_mf  = cfg_mf_en_i && !mlfa && mlfa_d;
    mlfa_d = mlfa;
    if (!vld) return;
    nw  = {mwin[5:0], b};
    hit = (nw == 7'b0011011);
    sb  = nw[6];
    ck  = (mpos == 7);
    ld  = 0;
    thr = cfg_thr4_i ? 4 : 3;
    case (mst)
      0: if (hit) begin ld = 1; mst = 1; end
      1: if (ck) mst = (!mff && sb) ? 2 : 0;
      2: if (ck) begin
           if (hit) begin mst = 3; mlfa = 0; mfc = 0; msc = 0; end
           else mst = 0;
         end
      default: if (ck) begin
           if (mff) begin
             if (hit) mfc = 0;
             else if (mfc + 1 >= thr) begin mst = 0; mlfa = 1; end
             else mfc++;
           end else begin
             if (!cfg_sw_loss_i || sb) msc = 0;
             else if (msc + 1 >= thr) begin mst = 0; mlfa = 1; end
             else msc++;
           end
         end
    endcase
    mwin = nw;
    if (ld) begin mpos = 8; mff = 1; end
    else if (mpos == 255) begin mpos = 0; mff = !mff; end
    else mpos++;
  endfunction

  // one cycle: drive now (at a falling edge), compare at the next falling edge
  task automatic cyc(input bit vld, input bit b);
    bit_vld_i = vld;
    bit_i     = b;
    @(posedge clk);
    model_edge(vld, b);
    @(negedge clk);
    chk(cur_tag, lfa_o, mlfa);
    chk("R7", lfa_irq_o, e_irq);
    chk("R8", frame_start_o, e_fs);
    chk("R9", mf_resync_o, e_mf);
  endtask

  task automatic send_bit(input bit b);
    while ($urandom_range(0, 7) == 0) cyc(1'b0, 1'($urandom));   // R10 gaps
    cyc(1'b1, b);
  endtask

  // fas_type: frame carrying the pattern; good: correct word; rnd: random fill
  task automatic send_frame(input bit fas_type, input bit good, input bit rnd);
    bit [7:0] ts0;
    if (fas_type) ts0 = good ? 8'b1_0011011 : 8'b1_0011111;
    else          ts0 = {1'b1, good, rnd ? 6'($urandom) : 6'b111111};
    for (int i = 7; i >= 0; i--) send_bit(ts0[i]);
    for (int i = 0; i < 248; i++) send_bit(rnd ? 1'($urandom) : 1'b1);
  endtask

  task automatic good_pairs(input int n);
    for (int i = 0; i < n; i++) begin
      send_frame(1, 1, 0);
      send_frame(0, 1, 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1e1f_0a11));
    @(negedge clk);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset values
    chk("R1", lfa_o, 1'b1);
    chk("R1", lfa_irq_o, 1'b0);
    chk("R1", frame_start_o, 1'b0);
    chk("R1", mf_resync_o, 1'b0);

    // R2/R3: acquire after an arbitrary bit offset
    cur_tag = "R3";
    for (int i = 0; i < 37; i++) send_bit(1'b1);
    good_pairs(3);
    chk("R3", lfa_o, 1'b0);

    // R5 threshold 3: two bad patterns keep alignment, three lose it
    cur_tag = "R5";
    cfg_thr4_i = 1'b0;
    repeat (2) begin send_frame(1, 0, 0); send_frame(0, 1, 0); end
    chk("R5", lfa_o, 1'b0);
    good_pairs(1);
    repeat (3) begin send_frame(1, 0, 0); send_frame(0, 1, 0); end
    chk("R5", lfa_o, 1'b1);

    // R4: failed service-word step, then a clean attempt
    cur_tag = "R4";
    send_frame(1, 1, 0);
    send_frame(0, 0, 0);
    send_frame(1, 1, 0);
    chk("R4", lfa_o, 1'b1);
    send_frame(0, 1, 0);
    send_frame(1, 1, 0);
    chk("R4", lfa_o, 1'b0);
    send_frame(0, 1, 0);

    // R5 threshold 4
    cur_tag = "R5";
    cfg_thr4_i = 1'b1;
    repeat (3) begin send_frame(1, 0, 0); send_frame(0, 1, 0); end
    chk("R5", lfa_o, 1'b0);
    send_frame(1, 0, 0); send_frame(0, 1, 0);
    chk("R5", lfa_o, 1'b1);
    good_pairs(2);
    chk("R5", lfa_o, 1'b0);

    // R6: service-word errors ignored, then counted
    cur_tag = "R6";
    cfg_thr4_i = 1'b0;
    cfg_sw_loss_i = 1'b0;
    repeat (5) begin send_frame(1, 1, 0); send_frame(0, 0, 0); end
    chk("R6", lfa_o, 1'b0);
    cfg_sw_loss_i = 1'b1;
    repeat (3) begin send_frame(1, 1, 0); send_frame(0, 0, 0); end
    chk("R6", lfa_o, 1'b1);

    // R9: regain without multiframe operation gives no request
    cur_tag = "R9";
    cfg_mf_en_i = 1'b0;
    good_pairs(2);
    chk("R9", lfa_o, 1'b0);

    // random phase: random fill, corruption and configuration
    cur_tag = "R2";
    for (int f = 0; f < 48; f++) begin
      if (f % 8 == 0) begin
        cfg_thr4_i    = 1'($urandom);
        cfg_sw_loss_i = 1'($urandom);
        cfg_mf_en_i   = 1'($urandom);
      end
      send_frame(f[0] == 1'b0, $urandom_range(0, 4) != 0, 1'b1);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule